// File: doc/BRIEF.md
# Three-Dimensional Remap Index Generator

This block walks up to three nested loop dimensions and yields one flattened element index per step. A 32-bit shape word gives each dimension's size, the nesting order of the three loops, an optional count-down direction for each dimension, one dimension whose contribution is dropped, and a small constant that is added to every index. A vector engine uses it to visit matrix elements in a non-sequential order, for example with the x and y loops swapped for a matrix multiply. Sizes need not be powers of two.

A start pulse captures the shape word and loads every counter with its start value. Each step-enable after that advances the innermost loop, carrying outward. A last-step flag marks the final element, and the step after it wraps all counters back to their start values. The two permute codes that would need indices read from registers are rejected: the block raises an unsupported flag and produces no valid output until the next start.

The control is a three-state machine. `ST_IDLE` is the reset state. `ST_RUN` generates indices. `ST_UNSUP` holds a rejected shape. Any state moves to `ST_RUN` on a start whose permute code is between 000 and 101. Any state moves to `ST_UNSUP` on a start with permute 110 or 111. Without a start, every state holds.

Top module: `remap_idx_gen`

## Requirements
- R1: The shape word layout, counted from bit 31 down, is as follows. [31:26] holds the x size minus one, [25:20] the y size minus one, and [19:14] the z size minus one. [13:11] holds the permute code. [10], [9] and [8] are the reverse flags for x, y and z. [7:4] holds the offset, [3:2] the skip code, and [1:0] is ignored. A size code n means n+1 elements (1 to 64), and every counter stays within 0 to n.
- R2: A start pulse sampled at a rising edge loads the shape and the counters, so that from the following cycle valid_o is 1 (permute 000 to 101) and the counters hold their start values. When start and step are high together, start wins.
- R3: The loop order, innermost first, is: 000 x,y,z; 001 x,z,y; 010 y,x,z; 011 y,z,x; 100 z,x,y; 101 z,y,x. On a step, the innermost counter advances. An outer counter advances only when every counter inside it is at its terminal value, and those inner counters then return to their start values.
- R4: A dimension whose reverse flag is clear starts at 0 and counts up to size-1. A dimension whose flag is set starts at size-1 and counts down to 0.
- R5: The index is the sum, over the dimensions, of each counter times the product of the sizes of the non-skipped dimensions inside it in loop order.
- R6: Skip code 01 drops x, 10 drops y and 11 drops z. The dropped dimension still steps through its loop, but it adds nothing to the index and does not scale the dimensions outside it. Code 00 drops none.
- R7: The 4-bit offset is added to every valid index.
- R8: last_o is 1 while valid and every counter is at its terminal value. A step in that cycle returns every counter to its start value.
- R9: Without start or step, the counters and the index hold their values.
- R10: A start with permute 110 or 111 gives unsup_o=1 and valid_o=0 from the next cycle, and steps have no effect until a new start.
- R11: After reset, valid_o, last_o, unsup_o, idx_o and all counters are 0. idx_o is 0 whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shape_i | input | 32 | Shape control word, captured on start |
| start_i | input | 1 | Capture shape and restart the walk |
| step_i | input | 1 | Advance to the next element |
| idx_o | output | 19 | Flattened, offset element index |
| cnt_x_o | output | 6 | Current x counter |
| cnt_y_o | output | 6 | Current y counter |
| cnt_z_o | output | 6 | Current z counter |
| valid_o | output | 1 | Index output is meaningful |
| last_o | output | 1 | Current element is the final one |
| unsup_o | output | 1 | Captured permute code is unsupported |

## Verification
A restart and a step can fall in the same cycle, and so can the final element and the wrap step. The bench raises start and step together in the middle of a walk, including with a new shape. It also steps in the cycle where last_o is high, so that the wrap happens. A reference model of nested loops in the bench predicts the counters, the flags and the index for every clock, and each prediction is compared with the design's outputs. The results show that start overrides the step and that the wrap returns each dimension to its own start value, whatever its direction.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_UNSUP = 2'd2
    } gen_state_e;

    // dimension codes: 0 = x, 1 = y, 2 = z
    // result packs {outer, middle, inner}, two bits each
    function automatic logic [5:0] loop_order(input logic [2:0] perm);
        logic [5:0] ord;
        case (perm)
            3'b000:  ord = {2'd2, 2'd1, 2'd0};
            3'b001:  ord = {2'd1, 2'd2, 2'd0};
            3'b010:  ord = {2'd2, 2'd0, 2'd1};
            3'b011:  ord = {2'd0, 2'd2, 2'd1};
            3'b100:  ord = {2'd1, 2'd0, 2'd2};
            3'b101:  ord = {2'd0, 2'd1, 2'd2};
            default: ord = {2'd2, 2'd1, 2'd0};
        endcase
        return ord;
    endfunction

    function automatic logic is_indexed(input logic [2:0] perm);
        return perm[2] & perm[1];
    endfunction

endpackage

// File: rtl/remap_dim_ctr.sv
module remap_dim_ctr #(
    parameter int SZ_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            adv_i,
    input  logic [SZ_W-1:0] size_m1_i,
    input  logic            rev_i,
    output logic [SZ_W-1:0] cnt_o,
    output logic            term_o
);

    logic [SZ_W-1:0] start_val;

    assign start_val = rev_i ? size_m1_i : '0;
    assign term_o    = rev_i ? (cnt_o == '0) : (cnt_o == size_m1_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= start_val;
        end else if (adv_i) begin
            if (term_o)
                cnt_o <= start_val;
            else if (rev_i)
                cnt_o <= cnt_o - 1'b1;
            else
                cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/remap_flatten.sv
module remap_flatten #(
    parameter int SZ_W  = 6,
    parameter int OFF_W = 4,
    parameter int IDX_W = 3 * SZ_W + 1
) (
    input  logic [SZ_W-1:0]  cnt_x_i,
    input  logic [SZ_W-1:0]  cnt_y_i,
    input  logic [SZ_W-1:0]  cnt_z_i,
    input  logic [SZ_W-1:0]  sz_x_i,
    input  logic [SZ_W-1:0]  sz_y_i,
    input  logic [SZ_W-1:0]  sz_z_i,
    input  logic [5:0]       order_i,
    input  logic [1:0]       skip_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [SZ_W-1:0]  cnt_a  [0:3];
    logic [SZ_W-1:0]  size_a [0:3];
    logic [IDX_W-1:0] stride;
    logic [IDX_W-1:0] acc;
    logic [1:0]       d;

    assign cnt_a[0]  = cnt_x_i;
    assign cnt_a[1]  = cnt_y_i;
    assign cnt_a[2]  = cnt_z_i;
    assign cnt_a[3]  = '0;
    assign size_a[0] = sz_x_i;
    assign size_a[1] = sz_y_i;
    assign size_a[2] = sz_z_i;
    assign size_a[3] = '0;

    always_comb begin
        stride = IDX_W'(1);
        acc    = IDX_W'(off_i);
        d      = 2'd0;
        for (int k = 0; k < 3; k++) begin
            d = order_i[2*k +: 2];
            if (skip_i != d + 2'd1) begin
                acc    = acc + IDX_W'(cnt_a[d]) * stride;
                stride = stride * (IDX_W'(size_a[d]) + IDX_W'(1));
            end
        end
        idx_o = acc;
    end

endmodule

// File: rtl/remap_idx_gen.sv
module remap_idx_gen
    import remap_pkg::*;
#(
    parameter int SZ_W   = 6,
    parameter int PERM_W = 3,
    parameter int OFF_W  = 4,
    parameter int SKIP_W = 2,
    parameter int MODE_W = 2,
    localparam int WORD_W = 3 * SZ_W + PERM_W + 3 + OFF_W + SKIP_W + MODE_W,
    localparam int IDX_W  = 3 * SZ_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] shape_i,
    input  logic              start_i,
    input  logic              step_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [SZ_W-1:0]   cnt_x_o,
    output logic [SZ_W-1:0]   cnt_y_o,
    output logic [SZ_W-1:0]   cnt_z_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              unsup_o
);

    localparam int X_LO = WORD_W - SZ_W;
    localparam int Y_LO = X_LO - SZ_W;
    localparam int Z_LO = Y_LO - SZ_W;
    localparam int P_LO = Z_LO - PERM_W;
    localparam int I_LO = P_LO - 3;
    localparam int O_LO = I_LO - OFF_W;
    localparam int S_LO = O_LO - SKIP_W;

    gen_state_e        state_q, state_d;
    logic [WORD_W-1:0] shape_q;
    logic [WORD_W-1:0] cur;
    logic [SZ_W-1:0]   sz   [0:2];
    logic [SZ_W-1:0]   cnt  [0:2];
    logic [2:0]        rev;
    logic [3:0]        term_v;
    logic [3:0]        adv_v;
    logic [5:0]        order;
    logic [PERM_W-1:0] perm;
    logic              go;
    logic              carry;
    logic [1:0]        d;
    logic [IDX_W-1:0]  flat_idx;
    logic              unused_mode_bits;

    assign unused_mode_bits = ^shape_i[S_LO-1:0];

    // fields come straight from the input in a start cycle so the load sees them
    assign cur    = start_i ? shape_i : shape_q;
    assign sz[0]  = cur[X_LO +: SZ_W];
    assign sz[1]  = cur[Y_LO +: SZ_W];
    assign sz[2]  = cur[Z_LO +: SZ_W];
    assign rev    = {cur[I_LO], cur[I_LO+1], cur[I_LO+2]};
    assign perm   = cur[P_LO +: PERM_W];
    assign order  = loop_order(perm);
    assign go     = (state_q == ST_RUN) && step_i && !start_i;

    // ripple carry through the loop order, innermost first
    always_comb begin
        adv_v = '0;
        carry = go;
        d     = 2'd0;
        for (int k = 0; k < 3; k++) begin
            d        = order[2*k +: 2];
            adv_v[d] = carry;
            carry    = carry & term_v[d];
        end
    end

    assign term_v[3] = 1'b1;

    for (genvar g = 0; g < 3; g++) begin : g_dim
        remap_dim_ctr #(.SZ_W(SZ_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (start_i),
            .adv_i     (adv_v[g]),
            .size_m1_i (sz[g]),
            .rev_i     (rev[g]),
            .cnt_o     (cnt[g]),
            .term_o    (term_v[g])
        );
    end

    remap_flatten #(.SZ_W(SZ_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_flat (
        .cnt_x_i (cnt[0]),
        .cnt_y_i (cnt[1]),
        .cnt_z_i (cnt[2]),
        .sz_x_i  (sz[0]),
        .sz_y_i  (sz[1]),
        .sz_z_i  (sz[2]),
        .order_i (order),
        .skip_i  (cur[S_LO +: SKIP_W]),
        .off_i   (cur[O_LO +: OFF_W]),
        .idx_o   (flat_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shape_q <= '0;
        else if (start_i)
            shape_q <= shape_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RUN, ST_UNSUP: begin
                if (start_i)
                    state_d = is_indexed(shape_i[P_LO +: PERM_W]) ? ST_UNSUP : ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        valid_o = (state_q == ST_RUN);
        unsup_o = (state_q == ST_UNSUP);
        last_o  = valid_o && (&term_v[2:0]);
        idx_o   = valid_o ? flat_idx : '0;
        cnt_x_o = cnt[0];
        cnt_y_o = cnt[1];
        cnt_z_o = cnt[2];
    end

endmodule

// File: rtl/remap_idx_chk.sv
module remap_idx_chk #(
    parameter int SZ_W   = 6,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 19,
    parameter int PERM_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              step_i,
    input logic [WORD_W-1:0] shape_i,
    input logic [WORD_W-1:0] shape_q,
    input logic [IDX_W-1:0]  idx_o,
    input logic [SZ_W-1:0]   cnt_x_o,
    input logic [SZ_W-1:0]   cnt_y_o,
    input logic [SZ_W-1:0]   cnt_z_o,
    input logic              valid_o,
    input logic              last_o,
    input logic              unsup_o
);

    localparam int X_LO = WORD_W - SZ_W;
    localparam int Y_LO = X_LO - SZ_W;
    localparam int Z_LO = Y_LO - SZ_W;
    localparam int P_LO = Z_LO - PERM_W;
    localparam int I_LO = P_LO - 3;

    logic [SZ_W-1:0] xm, ym, zm, xs, ys, zs;
    logic            new_bad;

    assign xm = shape_q[X_LO +: SZ_W];
    assign ym = shape_q[Y_LO +: SZ_W];
    assign zm = shape_q[Z_LO +: SZ_W];
    assign xs = shape_q[I_LO+2] ? xm : '0;
    assign ys = shape_q[I_LO+1] ? ym : '0;
    assign zs = shape_q[I_LO]   ? zm : '0;
    assign new_bad = shape_i[P_LO+2] & shape_i[P_LO+1];

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnt_x_o <= xm) && (cnt_y_o <= ym) && (cnt_z_o <= zm));

    assert_start_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !new_bad |=> valid_o && !unsup_o);

    assert_wrap_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && last_o && step_i && !start_i |=>
            (cnt_x_o == xs) && (cnt_y_o == ys) && (cnt_z_o == zs));

    assert_hold_idle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !step_i && !start_i |=>
            $stable(idx_o) && $stable(cnt_x_o) && $stable(cnt_y_o) && $stable(cnt_z_o));

    assert_reject_indexed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && new_bad |=> unsup_o && !valid_o && (idx_o == '0));

endmodule

bind remap_idx_gen remap_idx_chk #(
    .SZ_W(SZ_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .PERM_W(PERM_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
    .shape_i(shape_i), .shape_q(shape_q), .idx_o(idx_o),
    .cnt_x_o(cnt_x_o), .cnt_y_o(cnt_y_o), .cnt_z_o(cnt_z_o),
    .valid_o(valid_o), .last_o(last_o), .unsup_o(unsup_o)
);

// File: tb/test_remap_idx_gen.sv
`timescale 1ns/1ps
module test_remap_idx_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] shape = '0;
    logic        start = 1'b0;
    logic        step = 1'b0;
    logic [18:0] idx;
    logic [5:0]  cx, cy, cz;
    logic        valid, last, unsup;

    always #4 clk = ~clk;

    remap_idx_gen i_remap_idx_gen (
        .clk(clk), .rst_n(rst_n), .shape_i(shape), .start_i(start), .step_i(step),
        .idx_o(idx), .cnt_x_o(cx), .cnt_y_o(cy), .cnt_z_o(cz),
        .valid_o(valid), .last_o(last), .unsup_o(unsup)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 run, 2 rejected
    int          ms = 0;
    logic [31:0] msh = '0;
    int          mc [3] = '{0, 0, 0};

    function automatic int f_size(int d);
        case (d)
            0: return int'(msh[31:26]) + 1;
            1: return int'(msh[25:20]) + 1;
            default: return int'(msh[19:14]) + 1;
        endcase
    endfunction

    function automatic bit f_rev(int d);
        return msh[10 - d];
    endfunction

    function automatic int f_start(int d);
        return f_rev(d) ? f_size(d) - 1 : 0;
    endfunction

    function automatic bit f_term(int d);
        return f_rev(d) ? (mc[d] == 0) : (mc[d] == f_size(d) - 1);
    endfunction

    // innermost first
    function automatic int f_dim(int k);
        int tbl [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
        int p = int'(msh[13:11]);
        if (p > 5) p = 0;
        return tbl[p][k];
    endfunction

    function automatic int exp_idx();
        int s = 1;
        int a = int'(msh[7:4]);
        for (int k = 0; k < 3; k++) begin
            int d = f_dim(k);
            if (int'(msh[3:2]) != d + 1) begin
                a += mc[d] * s;
                s *= f_size(d);
            end
        end
        return a;
    endfunction

    function automatic logic [31:0] mk(int xm, int ym, int zm, int perm, int inv,
                                       int off, int skip, int mode);
        return {6'(xm), 6'(ym), 6'(zm), 3'(perm), 3'(inv), 4'(off), 2'(skip), 2'(mode)};
    endfunction

    task automatic model_edge(bit st, bit sp);
        if (st) begin
            msh = shape;
            ms = (msh[13] & msh[12]) ? 2 : 1;
            for (int d = 0; d < 3; d++) mc[d] = f_start(d);
        end else if (ms == 1 && sp) begin
            bit moved = 0;
            for (int k = 0; k < 3; k++) begin
                int d = f_dim(k);
                if (!moved) begin
                    if (f_term(d)) mc[d] = f_start(d);
                    else begin
                        mc[d] = f_rev(d) ? mc[d] - 1 : mc[d] + 1;
                        moved = 1;
                    end
                end
            end
        end
    endtask

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        bit ev = (ms == 1);
        bit el = ev && f_term(0) && f_term(1) && f_term(2);
        chk(tag, "valid", valid, ev);
        chk(tag, "unsup", unsup, ms == 2);
        chk(tag, "last", last, el);
        chk(tag, "idx", idx, ev ? exp_idx() : 0);
        chk(tag, "cnt_x", cx, mc[0]);
        chk(tag, "cnt_y", cy, mc[1]);
        chk(tag, "cnt_z", cz, mc[2]);
    endtask

    task automatic cyc(string tag, bit st, bit sp);
        start = st;
        step = sp;
        @(posedge clk);
        model_edge(st, sp);
        @(negedge clk);
        start = 0;
        step = 0;
        compare(tag);
    endtask

    task automatic run(string tag, logic [31:0] sh, int n);
        shape = sh;
        cyc(tag, 1, 0);
        for (int i = 0; i < n; i++) cyc(tag, 0, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R11 idle");
        cyc("R11 step while idle", 0, 1);

        // matrix-multiply style: y inner, then x, then z
        run("R3 R5 R8 perm010", mk(2, 1, 1, 3'b010, 0, 0, 0, 0), 14);
        // every order, with wrap
        for (int p = 0; p < 6; p++) run("R3 order", mk(2, 3, 1, p, 0, 0, 0, 0), 26);
        // reversed directions
        run("R4 reverse xz", mk(3, 1, 2, 3'b101, 3'b101, 0, 0, 0), 26);
        run("R4 reverse all", mk(1, 2, 4, 3'b011, 3'b111, 0, 0, 0), 32);
        // skip codes and offset
        for (int s = 0; s < 4; s++) run("R6 R7 skip", mk(2, 1, 2, 3'b000, 3'b010, 9, s, 0), 20);
        run("R7 max offset", mk(4, 0, 0, 3'b000, 0, 15, 0, 0), 6);
        // boundary sizes and ignored mode bits
        run("R1 size64", mk(63, 0, 1, 3'b000, 0, 0, 0, 3), 130);
        run("R1 size1", mk(0, 0, 0, 3'b100, 3'b111, 2, 0, 1), 3);

        // holding with gaps
        shape = mk(2, 2, 1, 3'b001, 3'b100, 5, 0, 0);
        cyc("R9 hold", 1, 0);
        for (int i = 0; i < 30; i++) cyc("R9 hold", 0, (i % 3) != 0);

        // start and step together, mid-walk and on the final element
        shape = mk(1, 2, 0, 3'b010, 0, 1, 0, 0);
        cyc("R2 restart", 1, 0);
        for (int i = 0; i < 3; i++) cyc("R2 walk", 0, 1);
        cyc("R2 start with step", 1, 1);
        shape = mk(2, 1, 1, 3'b110 ^ 3'b100, 3'b011, 3, 3, 0);
        for (int i = 0; i < 11; i++) cyc("R2 walk", 0, 1);
        cyc("R8 last then step", 0, 1);
        cyc("R2 new shape with step", 1, 1);
        for (int i = 0; i < 5; i++) cyc("R2 walk", 0, 1);

        // rejected permute codes
        run("R10 perm110", mk(2, 2, 2, 3'b110, 0, 4, 0, 0), 5);
        run("R10 perm111", mk(1, 1, 1, 3'b111, 0, 0, 0, 0), 5);
        run("R2 recover", mk(1, 1, 0, 3'b000, 0, 0, 0, 0), 5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule